// File: doc/BRIEF.md
# Serial Receive Word Buffer

This block is the receive side of one channel of a synchronous serial port. While the channel is enabled as a receiver, it samples the serial data pin whenever the external bit-clock enable is high. A frame-start strobe begins each word. Bits are collected most-significant first in a shift register until the programmed word length has arrived.

At the end of each word, the block moves the assembled bits into a 32-bit receive data register. The word is right-justified and the bits above it are zero. A core or a DMA engine takes the word through a valid/ready read port.

Each load raises a one-cycle interrupt pulse, unless the interrupt is masked or DMA mode is on. In DMA mode, a request level is raised for as long as a word is waiting. If a new word completes before the previous one was read, the new word replaces the old one. A sticky overflow flag is then set, and it stays set until software clears it with a write-one-to-clear pulse.

Top module: `serial_rx_buffer`

## Requirements
- R1: After reset, rd_valid_o, rd_data_o, ovf_o, irq_o and dma_req_o are all zero.
- R2: The first bit is sampled on the bit-clock enable cycle where fs_i is also high. Later bits follow MSB-first, one per enable. rd_valid_o is high from the clock edge that samples the last bit, and rd_data_o then holds the word with the first bit at position wlen_i-1.
- R3: For any wlen_i from 3 to 32, the word is right-justified: bits wlen_i and above of rd_data_o are zero.
- R4: Cycles with bclk_en_i low shift nothing, whatever sd_i does.
- R5: A frame start arriving in the middle of a word drops the partial word and restarts assembly with the bit sampled on that enable.
- R6: The held word stays unchanged while rd_ready_i is low. rd_valid_o falls at the edge where rd_valid_o and rd_ready_i are both high, unless a new word completes on that same edge.
- R7: If a word completes while rd_valid_o is high and rd_ready_i is low, ovf_o becomes 1 and rd_data_o takes the new word.
- R8: ovf_o stays at 1 until ovf_clr_i is high for one cycle. A new overflow on that same cycle keeps it set.
- R9: irq_o is high for exactly the one cycle after a load, and only when irq_mask_i and dma_mode_i are both 0.
- R10: With dma_mode_i at 1, dma_req_o equals rd_valid_o.
- R11: While rx_en_i is 0, no word is assembled or loaded.
- R12: After a word completes, bits with no new frame start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Channel enabled as receiver |
| bclk_en_i | input | 1 | Bit-clock enable, one sample per high cycle |
| fs_i | input | 1 | Frame-start strobe, sampled with bclk_en_i |
| sd_i | input | 1 | Serial data pin |
| wlen_i | input | 6 | Word length in bits, 3 to 32 |
| dma_mode_i | input | 1 | 1 = DMA consumes words, interrupt suppressed |
| irq_mask_i | input | 1 | 1 = interrupt masked |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| rd_ready_i | input | 1 | Reader accepts the held word |
| rd_valid_o | output | 1 | Receive register holds an unread word |
| rd_data_o | output | 32 | Receive register contents |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Data-available interrupt pulse |
| dma_req_o | output | 1 | DMA request level |

## Verification
The load happens on the same edge that samples the last bit. rd_valid_o, rd_data_o, ovf_o and the one-cycle irq_o pulse are therefore all due one edge after the final enable, and the bench reads them 1 ns after that edge. A read takes effect one edge after both valid and ready are seen high, so the scoreboard monitor samples the handshake on the falling edge, between input changes and the edge that acts on them. The bench changes its inputs 1 ns after each rising edge so that no sample races the clock.

// File: rtl/serial_rx_buffer_pkg.sv
package serial_rx_buffer_pkg;
   localparam int unsigned MIN_WORD_LEN = 3;

   typedef struct packed {
      logic dma_mode;
      logic irq_mask;
   } notify_cfg_t;
endpackage

// File: rtl/srb_shifter.sv
module srb_shifter #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              bclk_en_i,
   input  logic              fs_i,
   input  logic              sd_i,
   input  logic [CNT_W-1:0]  wlen_i,
   output logic              done_o,
   output logic [DATA_W-1:0] word_o
);
   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              active_q;
   logic              take;

   always_comb begin
      take   = en_i & bclk_en_i;
      word_o = {shreg_q[DATA_W-2:0], sd_i};
      done_o = take & ~fs_i & active_q & ((cnt_q + CNT_W'(1)) == wlen_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shreg_q  <= '0;
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (!en_i) begin
         active_q <= 1'b0;
      end else if (take) begin
         if (fs_i) begin
            shreg_q  <= {{(DATA_W-1){1'b0}}, sd_i};
            cnt_q    <= CNT_W'(1);
            active_q <= 1'b1;
         end else if (active_q) begin
            shreg_q <= word_o;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (done_o) active_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/srb_holding.sv
module srb_holding #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic [CNT_W-1:0]  wlen_i,
   input  logic              rd_ready_i,
   input  logic              ovf_clr_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              ovf_o
);
   logic [DATA_W-1:0] keep;

   for (genvar b = 0; b < DATA_W; b++) begin : g_keep
      assign keep[b] = (CNT_W'(b) < wlen_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         ovf_o   <= 1'b0;
      end else begin
         if (load_i) begin
            data_o  <= word_i & keep;
            valid_o <= 1'b1;
         end else if (valid_o && rd_ready_i) begin
            valid_o <= 1'b0;
         end
         if (load_i && valid_o && !rd_ready_i) ovf_o <= 1'b1;
         else if (ovf_clr_i)                   ovf_o <= 1'b0;
      end
   end
endmodule

// File: rtl/srb_notify.sv
module srb_notify
   import serial_rx_buffer_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        load_i,
   input  logic        valid_i,
   input  notify_cfg_t cfg_i,
   output logic        irq_o,
   output logic        dma_req_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= 1'b0;
      else         irq_o <= load_i & ~cfg_i.irq_mask & ~cfg_i.dma_mode;
   end

   assign dma_req_o = valid_i & cfg_i.dma_mode;
endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
   import serial_rx_buffer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rx_en_i,
   input  logic              bclk_en_i,
   input  logic              fs_i,
   input  logic              sd_i,
   input  logic [CNT_W-1:0]  wlen_i,
   input  logic              dma_mode_i,
   input  logic              irq_mask_i,
   input  logic              ovf_clr_i,
   input  logic              rd_ready_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              ovf_o,
   output logic              irq_o,
   output logic              dma_req_o
);
   if (DATA_W < MIN_WORD_LEN) begin : g_bad_width
      $error("serial_rx_buffer: DATA_W below minimum word length");
   end

   logic              word_done;
   logic [DATA_W-1:0] word_bits;
   notify_cfg_t       cfg;

   assign cfg = '{dma_mode: dma_mode_i, irq_mask: irq_mask_i};

   srb_shifter #(.DATA_W(DATA_W)) shifter_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .bclk_en_i(bclk_en_i),
      .fs_i(fs_i), .sd_i(sd_i), .wlen_i(wlen_i),
      .done_o(word_done), .word_o(word_bits)
   );

   srb_holding #(.DATA_W(DATA_W)) holding_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(word_done), .word_i(word_bits),
      .wlen_i(wlen_i), .rd_ready_i(rd_ready_i), .ovf_clr_i(ovf_clr_i),
      .valid_o(rd_valid_o), .data_o(rd_data_o), .ovf_o(ovf_o)
   );

   srb_notify notify_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(word_done), .valid_i(rd_valid_o),
      .cfg_i(cfg), .irq_o(irq_o), .dma_req_o(dma_req_o)
   );
endmodule

// File: rtl/serial_rx_buffer_chk.sv
module serial_rx_buffer_chk #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              done_i,
   input logic [DATA_W-1:0] word_i,
   input logic [CNT_W-1:0]  wlen_i,
   input logic              rd_valid_i,
   input logic              rd_ready_i,
   input logic              ovf_i,
   input logic              ovf_clr_i,
   input logic              irq_i,
   input logic              dma_req_i
);
   // R2
   load_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> rd_valid_i);
   // R3
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && (32'(wlen_i) < DATA_W)) |-> ((word_i >> wlen_i) == '0));
   // R6
   read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && rd_ready_i && !done_i) |=> !rd_valid_i);
   // R7
   overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i && rd_valid_i && !rd_ready_i) |=> ovf_i);
   // R8
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_i && !ovf_clr_i) |=> ovf_i);
   // R9
   irq_with_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i |-> rd_valid_i);
   // R10
   dma_req_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_i |-> rd_valid_i);
endmodule

bind serial_rx_buffer serial_rx_buffer_chk #(.DATA_W(DATA_W)) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .done_i(word_done), .word_i(word_bits),
   .wlen_i(wlen_i), .rd_valid_i(rd_valid_o), .rd_ready_i(rd_ready_i),
   .ovf_i(ovf_o), .ovf_clr_i(ovf_clr_i), .irq_i(irq_o), .dma_req_i(dma_req_o)
);

// File: tb/serial_rx_buffer_tb_top.sv
module serial_rx_buffer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0, bclk_en = 1'b0, fs = 1'b0, sd = 1'b0;
   logic [5:0]  wlen = 6'd8;
   logic        dma_mode = 1'b0, irq_mask = 1'b0, ovf_clr = 1'b0, rd_ready = 1'b0;
   logic        rd_valid, ovf, irq, dma_req;
   logic [31:0] rd_data;

   int total = 0;
   int bad = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   serial_rx_buffer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .bclk_en_i(bclk_en),
      .fs_i(fs), .sd_i(sd), .wlen_i(wlen), .dma_mode_i(dma_mode),
      .irq_mask_i(irq_mask), .ovf_clr_i(ovf_clr), .rd_ready_i(rd_ready),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ovf_o(ovf),
      .irq_o(irq), .dma_req_o(dma_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] trim(input int len, input logic [31:0] v);
      logic [63:0] m = (64'd1 << len) - 64'd1;
      return v & m[31:0];
   endfunction

   task automatic expect_word(input int len, input logic [31:0] v, input string req);
      exp_q.push_back(trim(len, v));
      tag_q.push_back(req);
   endtask

   // Drives nbits bits of v MSB-first from bit len-1; frame start on first bit if with_fs.
   task automatic send(input int len, input logic [31:0] v, input int gap,
                       input bit with_fs, input int nbits);
      wlen = 6'(len);
      for (int i = 0; i < nbits; i++) begin
         for (int g = 0; g < gap; g++) begin
            @(posedge clk); #1;
            sd = ~sd;
         end
         @(posedge clk); #1;
         bclk_en = 1'b1;
         sd = v[len-1-i];
         fs = with_fs && (i == 0);
         @(posedge clk); #1;
         bclk_en = 1'b0;
         fs = 1'b0;
         sd = ~sd;
      end
   endtask

   // Scoreboard monitor: a handshake is decided by the values seen here.
   always @(negedge clk) begin
      if (rst_n && rd_valid && rd_ready) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R12: actual=%h expected=no word", rd_data);
         end else begin
            automatic string t = tag_q.pop_front();
            check(t, rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1;
      // R1
      check("R1", {28'd0, rd_valid, ovf, irq, dma_req}, 32'd0);
      check("R1", rd_data, 32'd0);
      repeat (3) @(posedge clk); #1;
      rst_n = 1'b1; rx_en = 1'b1; rd_ready = 1'b1;

      // R2, R4 with gaps and noise on sd
      expect_word(8, 32'hA5, "R2");
      send(8, 32'hA5, 0, 1, 8);
      expect_word(8, 32'h3C, "R4");
      send(8, 32'h3C, 3, 1, 8);
      // R3 length corners
      expect_word(3, 32'h5, "R3");
      send(3, 32'h5, 1, 1, 3);
      expect_word(32, 32'hDEADBEEF, "R3");
      send(32, 32'hDEADBEEF, 0, 1, 32);
      expect_word(17, 32'hFFFF_A5C3, "R3");
      send(17, 32'hFFFF_A5C3, 2, 1, 17);
      // R5 restart mid-word
      send(8, 32'hFF, 0, 1, 5);
      expect_word(8, 32'h81, "R5");
      send(8, 32'h81, 0, 1, 8);
      // R12 bits without frame start
      repeat (3) @(posedge clk); #1;
      send(8, 32'h7E, 0, 0, 8);
      repeat (2) @(posedge clk); #1;
      check("R12", {31'd0, rd_valid}, 32'd0);
      // R11 receiver disabled
      rx_en = 1'b0;
      send(8, 32'h66, 0, 1, 8);
      repeat (2) @(posedge clk); #1;
      check("R11", {31'd0, rd_valid}, 32'd0);
      rx_en = 1'b1;

      // R9, R6, R7, R8 with reader stalled
      rd_ready = 1'b0;
      send(8, 32'h3C, 0, 1, 8);
      check("R9", {31'd0, irq}, 32'd1);
      check("R2", rd_data, 32'h3C);
      repeat (3) @(posedge clk); #1;
      check("R9", {31'd0, irq}, 32'd0);
      check("R6", {rd_data[30:0], rd_valid}, {31'h3C, 1'b1});
      send(12, 32'hC3A, 1, 1, 12);
      check("R7", {31'd0, ovf}, 32'd1);
      check("R7", rd_data, 32'hC3A);
      repeat (5) @(posedge clk); #1;
      check("R8", {31'd0, ovf}, 32'd1);
      ovf_clr = 1'b1;
      @(posedge clk); #1;
      ovf_clr = 1'b0;
      check("R8", {31'd0, ovf}, 32'd0);
      expect_word(12, 32'hC3A, "R6");
      rd_ready = 1'b1;
      @(posedge clk); #1;
      rd_ready = 1'b0;
      check("R6", {31'd0, rd_valid}, 32'd0);

      // R9 masked
      irq_mask = 1'b1;
      send(8, 32'h5A, 0, 1, 8);
      check("R9", {30'd0, irq, rd_valid}, 32'd1);
      expect_word(8, 32'h5A, "R9");
      rd_ready = 1'b1;
      @(posedge clk); #1;
      rd_ready = 1'b0;
      irq_mask = 1'b0;

      // R10 DMA mode
      dma_mode = 1'b1;
      send(8, 32'h99, 0, 1, 8);
      check("R10", {30'd0, irq, dma_req}, 32'd1);
      expect_word(8, 32'h99, "R10");
      rd_ready = 1'b1;
      @(posedge clk); #1;
      rd_ready = 1'b0;
      check("R10", {31'd0, dma_req}, 32'd0);
      dma_mode = 1'b0;

      repeat (3) @(posedge clk); #1;
      check("R2", 32'(exp_q.size()), 32'd0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule